// File: doc/BRIEF.md
# Dual-Depth UART FIFO Controller

This block holds the transmit and receive character queues of a serial port. The host side writes transmit characters and reads receive characters. The line side pops transmit characters and pushes receive characters. The queues run in one of three depth modes. With the queues disabled, each direction holds a single character. In the shallow mode each direction holds 64 characters, and in the deep mode each holds 256. The mode is picked by an enable bit and a depth bit, and any change of mode empties both queues.

The block also produces the interrupt trigger flags and the flow-control stop signal. The thresholds behind them come from one of two sources. In the shallow mode, four 2-bit codes each select a value from a fixed table. In the deep mode, four byte-wide level registers supply the thresholds, and the host can write them. The active thresholds are always visible on outputs. The transmit free space and the receive fill count are also reported at all times.

A character that arrives at a full queue is dropped. A dropped receive character raises an overrun flag, which stays set until the host reads status.

Top module: `uart_dual_fifo`

## Requirements
- R1: Capacity per direction is 1 when `fifo_en`=0, 64 when `fifo_en`=1 and `fifo_deep`=0, and 256 when both are 1. `tx_free` equals capacity minus stored transmit characters, and `rx_count` equals stored receive characters.
- R2: Each queue returns characters in arrival order, including across pointer wrap. The head character is visible on `tx_dout`/`rx_dout` before it is popped.
- R3: A transmit write or receive push made while that queue is full is discarded, and its count is unchanged. A pop or read of an empty queue is ignored.
- R4: `rx_overrun` is set at the edge where a receive push is dropped. It clears at the edge where `stat_rd` is high, unless a drop happens in that same cycle.
- R5: In shallow mode, the codes map 00, 01, 10, 11 to these levels: transmit trigger 8, 16, 32, 56; receive trigger 8, 16, 56, 60; upper 8, 16, 56, 60; lower 0, 8, 16, 56. The active levels appear on the `lvl_*` outputs.
- R6: Level register writes use `lvl_wr_sel` 0 for transmit trigger, 1 for receive trigger, 2 for upper and 3 for lower. A write is accepted only in deep mode and is ignored in any other mode. The reset values are 16, 16, 240 and 16.
- R7: In deep mode, the levels come from the level registers, and the four codes have no effect.
- R8: When enabled, `tx_irq` is high while the stored transmit count is at or below the transmit trigger level. `rx_irq` is high while `rx_count` is nonzero and at or above the receive trigger level. In single mode, `tx_irq` means the transmit queue is empty and `rx_irq` means the receive queue is not empty. Both flags follow the counts in the same cycle.
- R9: `flow_stop` is set one edge after `rx_count` exceeds the upper level, and cleared one edge after `rx_count` falls below the lower level; otherwise it holds. It is low in single mode and is cleared by a mode change.
- R10: A change of `{fifo_en, fifo_deep}` empties both queues at the next edge. Pushes and pops in that cycle are ignored. The new mode applies from that edge.
- R11: An accepted push and an accepted pop in the same cycle leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_en | input | 1 | Queue enable |
| fifo_deep | input | 1 | Deep (256) mode select |
| code_tx_trig | input | 2 | Shallow-mode transmit trigger code |
| code_rx_trig | input | 2 | Shallow-mode receive trigger code |
| code_upper | input | 2 | Shallow-mode upper (stop) level code |
| code_lower | input | 2 | Shallow-mode lower (resume) level code |
| lvl_wr_en | input | 1 | Level register write strobe |
| lvl_wr_sel | input | 2 | Level register select |
| lvl_wr_data | input | 8 | Level register write value |
| tx_wr_en | input | 1 | Host transmit write |
| tx_wr_data | input | 8 | Host transmit character |
| tx_pop | input | 1 | Line side takes transmit head |
| tx_dout | output | 8 | Transmit head character |
| tx_empty | output | 1 | Transmit queue empty |
| rx_push | input | 1 | Line side receive push |
| rx_din | input | 8 | Received character |
| rx_rd | input | 1 | Host receive read |
| rx_dout | output | 8 | Receive head character |
| rx_empty | output | 1 | Receive queue empty |
| stat_rd | input | 1 | Status read, clears overrun |
| tx_free | output | 9 | Transmit free space |
| rx_count | output | 9 | Receive fill count |
| tx_irq | output | 1 | Transmit trigger flag |
| rx_irq | output | 1 | Receive trigger flag |
| flow_stop | output | 1 | Flow-control stop request |
| rx_overrun | output | 1 | Receive overrun flag |
| lvl_tx_trig | output | 8 | Active transmit trigger level |
| lvl_rx_trig | output | 8 | Active receive trigger level |
| lvl_upper | output | 8 | Active upper level |
| lvl_lower | output | 8 | Active lower level |

## Verification
Counts, `tx_free`, the head characters and `rx_overrun` change at the edge that samples the push, pop or status read, so the bench checks them just after that edge. The level outputs and both trigger flags are combinational from the counts and the registered mode, so they are checked in the same window. `flow_stop` lags the count by one more edge, and the bench waits an extra cycle before checking it. A mode change empties the queues at the edge that samples it, and every scenario steps one cycle after changing the mode before it checks anything.

// File: rtl/ufifo_pkg.sv
package ufifo_pkg;

    localparam int DATA_W        = 8;
    localparam int DEEP_DEPTH    = 256;
    localparam int SHALLOW_DEPTH = 64;
    localparam int LVL_W         = 8;

    typedef enum logic [1:0] {
        MODE_SINGLE  = 2'd0,
        MODE_SHALLOW = 2'd1,
        MODE_DEEP    = 2'd2
    } depth_mode_e;

    typedef enum logic [1:0] {
        SEL_TX_TRIG = 2'd0,
        SEL_RX_TRIG = 2'd1,
        SEL_UPPER   = 2'd2,
        SEL_LOWER   = 2'd3
    } lvl_sel_e;

    typedef struct packed {
        logic [1:0] tx_trig;
        logic [1:0] rx_trig;
        logic [1:0] upper;
        logic [1:0] lower;
    } lvl_codes_t;

    typedef struct packed {
        logic [LVL_W-1:0] tx_trig;
        logic [LVL_W-1:0] rx_trig;
        logic [LVL_W-1:0] upper;
        logic [LVL_W-1:0] lower;
    } lvl_set_t;

    localparam lvl_set_t LVL_RESET = '{
        tx_trig: LVL_W'(16),
        rx_trig: LVL_W'(16),
        upper:   LVL_W'(240),
        lower:   LVL_W'(16)
    };

    function automatic depth_mode_e mode_of(input logic en, input logic deep);
        if (!en)       return MODE_SINGLE;
        else if (deep) return MODE_DEEP;
        else           return MODE_SHALLOW;
    endfunction

    function automatic logic [LVL_W-1:0] tbl_tx(input logic [1:0] c);
        case (c)
            2'd0:    return LVL_W'(8);
            2'd1:    return LVL_W'(16);
            2'd2:    return LVL_W'(32);
            default: return LVL_W'(56);
        endcase
    endfunction

    function automatic logic [LVL_W-1:0] tbl_rx(input logic [1:0] c);
        case (c)
            2'd0:    return LVL_W'(8);
            2'd1:    return LVL_W'(16);
            2'd2:    return LVL_W'(56);
            default: return LVL_W'(60);
        endcase
    endfunction

    function automatic logic [LVL_W-1:0] tbl_upper(input logic [1:0] c);
        case (c)
            2'd0:    return LVL_W'(8);
            2'd1:    return LVL_W'(16);
            2'd2:    return LVL_W'(56);
            default: return LVL_W'(60);
        endcase
    endfunction

    function automatic logic [LVL_W-1:0] tbl_lower(input logic [1:0] c);
        case (c)
            2'd0:    return LVL_W'(0);
            2'd1:    return LVL_W'(8);
            2'd2:    return LVL_W'(16);
            default: return LVL_W'(56);
        endcase
    endfunction

endpackage

// File: rtl/ufifo_ring.sv
module ufifo_ring #(
    parameter int DW    = 8,
    parameter int DEPTH = 256
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   flush,
    input  logic [$clog2(DEPTH):0] cap,
    input  logic                   push,
    input  logic [DW-1:0]          din,
    input  logic                   pop,
    output logic [DW-1:0]          dout,
    output logic [$clog2(DEPTH):0] count,
    output logic                   empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr, mask;
    logic [CW-1:0] cap_m1;
    logic          full, do_push, do_pop;

    // Capacity is a power of two, so wrap is a mask of the low pointer bits.
    assign cap_m1  = cap - CW'(1);
    assign mask    = cap_m1[AW-1:0];
    assign full    = (count >= cap);
    assign empty   = (count == '0);
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign dout    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr + AW'(1)) & mask;
            if (do_pop)  rd_ptr <= (rd_ptr + AW'(1)) & mask;
            case ({do_push, do_pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

endmodule

// File: rtl/ufifo_levels.sv
module ufifo_levels
    import ufifo_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             deep_active,
    input  lvl_codes_t       codes,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [LVL_W-1:0] wr_data,
    output lvl_set_t         levels
);
    lvl_set_t regs_q;
    lvl_set_t table_v;

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q <= LVL_RESET;
        end else if (wr_en && deep_active) begin
            case (lvl_sel_e'(wr_sel))
                SEL_TX_TRIG: regs_q.tx_trig <= wr_data;
                SEL_RX_TRIG: regs_q.rx_trig <= wr_data;
                SEL_UPPER:   regs_q.upper   <= wr_data;
                default:     regs_q.lower   <= wr_data;
            endcase
        end
    end

    always_comb begin
        table_v.tx_trig = tbl_tx(codes.tx_trig);
        table_v.rx_trig = tbl_rx(codes.rx_trig);
        table_v.upper   = tbl_upper(codes.upper);
        table_v.lower   = tbl_lower(codes.lower);
    end

    assign levels = deep_active ? regs_q : table_v;

endmodule

// File: rtl/ufifo_flow.sv
module ufifo_flow
    import ufifo_pkg::*;
#(
    parameter int CW = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             enabled,
    input  logic [CW-1:0]    rx_count,
    input  logic [LVL_W-1:0] upper,
    input  logic [LVL_W-1:0] lower,
    input  logic             rx_drop,
    input  logic             stat_rd,
    output logic             flow_stop,
    output logic             overrun
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flow_stop <= 1'b0;
        end else if (flush || !enabled) begin
            flow_stop <= 1'b0;
        end else if (rx_count > CW'(upper)) begin
            flow_stop <= 1'b1;
        end else if (rx_count < CW'(lower)) begin
            flow_stop <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)          overrun <= 1'b0;
        else if (rx_drop) overrun <= 1'b1;
        else if (stat_rd) overrun <= 1'b0;
    end

endmodule

// File: rtl/uart_dual_fifo.sv
module uart_dual_fifo
    import ufifo_pkg::*;
#(
    parameter int DW      = DATA_W,
    parameter int DEEP    = DEEP_DEPTH,
    parameter int SHALLOW = SHALLOW_DEPTH
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  fifo_en,
    input  logic                  fifo_deep,
    input  logic [1:0]            code_tx_trig,
    input  logic [1:0]            code_rx_trig,
    input  logic [1:0]            code_upper,
    input  logic [1:0]            code_lower,
    input  logic                  lvl_wr_en,
    input  logic [1:0]            lvl_wr_sel,
    input  logic [LVL_W-1:0]      lvl_wr_data,
    input  logic                  tx_wr_en,
    input  logic [DW-1:0]         tx_wr_data,
    input  logic                  tx_pop,
    output logic [DW-1:0]         tx_dout,
    output logic                  tx_empty,
    input  logic                  rx_push,
    input  logic [DW-1:0]         rx_din,
    input  logic                  rx_rd,
    output logic [DW-1:0]         rx_dout,
    output logic                  rx_empty,
    input  logic                  stat_rd,
    output logic [$clog2(DEEP):0] tx_free,
    output logic [$clog2(DEEP):0] rx_count,
    output logic                  tx_irq,
    output logic                  rx_irq,
    output logic                  flow_stop,
    output logic                  rx_overrun,
    output logic [LVL_W-1:0]      lvl_tx_trig,
    output logic [LVL_W-1:0]      lvl_rx_trig,
    output logic [LVL_W-1:0]      lvl_upper,
    output logic [LVL_W-1:0]      lvl_lower
);
    localparam int CW = $clog2(DEEP) + 1;

    depth_mode_e mode_q, mode_d;
    logic        mode_flush;
    logic [CW-1:0] cur_cap, tx_count;
    logic        rx_drop;
    lvl_codes_t  codes;
    lvl_set_t    levels;

    assign mode_d     = mode_of(fifo_en, fifo_deep);
    assign mode_flush = (mode_d != mode_q);

    always_ff @(posedge clk) begin
        if (rst) mode_q <= MODE_SINGLE;
        else     mode_q <= mode_d;
    end

    always_comb begin
        case (mode_q)
            MODE_SINGLE:  cur_cap = CW'(1);
            MODE_SHALLOW: cur_cap = CW'(SHALLOW);
            default:      cur_cap = CW'(DEEP);
        endcase
    end

    ufifo_ring #(.DW(DW), .DEPTH(DEEP)) u_tx_ring (
        .clk   (clk),
        .rst   (rst),
        .flush (mode_flush),
        .cap   (cur_cap),
        .push  (tx_wr_en),
        .din   (tx_wr_data),
        .pop   (tx_pop),
        .dout  (tx_dout),
        .count (tx_count),
        .empty (tx_empty)
    );

    ufifo_ring #(.DW(DW), .DEPTH(DEEP)) u_rx_ring (
        .clk   (clk),
        .rst   (rst),
        .flush (mode_flush),
        .cap   (cur_cap),
        .push  (rx_push),
        .din   (rx_din),
        .pop   (rx_rd),
        .dout  (rx_dout),
        .count (rx_count),
        .empty (rx_empty)
    );

    assign tx_free = cur_cap - tx_count;
    assign rx_drop = rx_push && (rx_count >= cur_cap) && !mode_flush;

    assign codes = '{tx_trig: code_tx_trig, rx_trig: code_rx_trig,
                     upper: code_upper, lower: code_lower};

    ufifo_levels u_levels (
        .clk         (clk),
        .rst         (rst),
        .deep_active (mode_q == MODE_DEEP),
        .codes       (codes),
        .wr_en       (lvl_wr_en),
        .wr_sel      (lvl_wr_sel),
        .wr_data     (lvl_wr_data),
        .levels      (levels)
    );

    assign lvl_tx_trig = levels.tx_trig;
    assign lvl_rx_trig = levels.rx_trig;
    assign lvl_upper   = levels.upper;
    assign lvl_lower   = levels.lower;

    always_comb begin
        if (mode_q == MODE_SINGLE) begin
            tx_irq = (tx_count == '0);
            rx_irq = (rx_count != '0);
        end else begin
            tx_irq = (tx_count <= CW'(levels.tx_trig));
            rx_irq = (rx_count != '0) && (rx_count >= CW'(levels.rx_trig));
        end
    end

    ufifo_flow #(.CW(CW)) u_flow (
        .clk       (clk),
        .rst       (rst),
        .flush     (mode_flush),
        .enabled   (mode_q != MODE_SINGLE),
        .rx_count  (rx_count),
        .upper     (levels.upper),
        .lower     (levels.lower),
        .rx_drop   (rx_drop),
        .stat_rd   (stat_rd),
        .flow_stop (flow_stop),
        .overrun   (rx_overrun)
    );

endmodule

// File: rtl/ufifo_chk.sv
module ufifo_chk #(
    parameter int CW = $clog2(ufifo_pkg::DEEP_DEPTH) + 1
) (
    input logic          clk,
    input logic          rst,
    input logic          mode_flush,
    input logic [CW-1:0] cur_cap,
    input logic [CW-1:0] rx_count,
    input logic [CW-1:0] tx_count,
    input logic          rx_push,
    input logic          rx_rd,
    input logic          tx_wr_en,
    input logic          tx_pop,
    input logic          rx_drop,
    input logic          stat_rd,
    input logic          flow_stop,
    input logic          rx_overrun,
    input logic [7:0]    lvl_upper,
    input logic [7:0]    lvl_lower
);
    // R1
    count_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_count <= cur_cap) && (tx_count <= cur_cap));

    // R3
    rx_full_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_count == cur_cap && rx_push && !rx_rd && !mode_flush) |=> (rx_count == $past(rx_count)));

    // R3
    tx_full_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_count == cur_cap && tx_wr_en && !tx_pop && !mode_flush) |=> (tx_count == $past(tx_count)));

    // R4
    ovr_set_chk: assert property (@(posedge clk) disable iff (rst)
        rx_drop |=> rx_overrun);

    // R4
    ovr_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (stat_rd && !rx_drop) |=> !rx_overrun);

    // R9
    flow_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(flow_stop) |-> ($past(rx_count) > CW'($past(lvl_upper))));

    // R9
    flow_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(flow_stop) |-> (($past(rx_count) < CW'($past(lvl_lower))) || $past(mode_flush)));

    // R10
    flush_empty_chk: assert property (@(posedge clk) disable iff (rst)
        mode_flush |=> (rx_count == '0 && tx_count == '0));

    // R11
    rx_step_chk: assert property (@(posedge clk) disable iff (rst)
        !mode_flush |=> (rx_count == $past(rx_count) || rx_count == $past(rx_count) + CW'(1)
                         || rx_count + CW'(1) == $past(rx_count)));

endmodule

bind uart_dual_fifo ufifo_chk u_ufifo_chk (.*);

// File: tb/test_uart_dual_fifo.sv
module test_uart_dual_fifo;
    logic       clk = 1'b0;
    logic       rst;
    logic       fifo_en, fifo_deep;
    logic [1:0] code_tx_trig, code_rx_trig, code_upper, code_lower;
    logic       lvl_wr_en;
    logic [1:0] lvl_wr_sel;
    logic [7:0] lvl_wr_data;
    logic       tx_wr_en, tx_pop, tx_empty;
    logic [7:0] tx_wr_data, tx_dout;
    logic       rx_push, rx_rd, rx_empty, stat_rd;
    logic [7:0] rx_din, rx_dout;
    logic [8:0] tx_free, rx_count;
    logic       tx_irq, rx_irq, flow_stop, rx_overrun;
    logic [7:0] lvl_tx_trig, lvl_rx_trig, lvl_upper, lvl_lower;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #5ns clk = ~clk;

    uart_dual_fifo i_uart_dual_fifo (.*);

    task automatic tick();
        @(posedge clk);
        #1ns;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic set_mode(input logic en, input logic deep);
        fifo_en = en; fifo_deep = deep;
        tick();
    endtask

    task automatic push_rx(input logic [7:0] v);
        rx_push = 1'b1; rx_din = v;
        tick();
        rx_push = 1'b0;
    endtask

    task automatic write_tx(input logic [7:0] v);
        tx_wr_en = 1'b1; tx_wr_data = v;
        tick();
        tx_wr_en = 1'b0;
    endtask

    task automatic read_rx(input string req, input logic [7:0] exp);
        chk(req, rx_dout, exp);
        rx_rd = 1'b1;
        tick();
        rx_rd = 1'b0;
    endtask

    task automatic wr_lvl(input logic [1:0] sel, input logic [7:0] v);
        lvl_wr_en = 1'b1; lvl_wr_sel = sel; lvl_wr_data = v;
        tick();
        lvl_wr_en = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 reset rx_count", rx_count, 0);
        chk("R1 reset tx_free single", tx_free, 1);
        chk("R9 reset flow_stop", flow_stop, 0);
        chk("R4 reset overrun", rx_overrun, 0);
        chk("R8 single tx_irq empty", tx_irq, 1);
        chk("R8 single rx_irq empty", rx_irq, 0);
    endtask

    task automatic t_single();
        write_tx(8'hA1);
        chk("R1 single tx_free full", tx_free, 0);
        chk("R8 single tx_irq", tx_irq, 0);
        write_tx(8'hB2);
        chk("R3 single tx drop", tx_free, 0);
        chk("R2 single tx head", tx_dout, 8'hA1);
        tx_pop = 1'b1; tick(); tx_pop = 1'b0;
        chk("R1 single tx_free after pop", tx_free, 1);
        tx_pop = 1'b1; tick(); tx_pop = 1'b0;
        chk("R3 pop empty ignored", tx_free, 1);
        push_rx(8'h11);
        chk("R8 single rx_irq", rx_irq, 1);
        chk("R4 no overrun yet", rx_overrun, 0);
        push_rx(8'h22);
        chk("R3 single rx drop count", rx_count, 1);
        chk("R4 overrun set", rx_overrun, 1);
        chk("R3 single rx head kept", rx_dout, 8'h11);
        stat_rd = 1'b1; tick(); stat_rd = 1'b0;
        chk("R4 overrun cleared", rx_overrun, 0);
    endtask

    task automatic t_shallow();
        set_mode(1'b1, 1'b0);
        chk("R10 flush on enable", rx_count, 0);
        chk("R1 shallow tx_free", tx_free, 64);
        for (int i = 0; i < 64; i++) push_rx(8'(i * 3 + 1));
        chk("R1 shallow rx full", rx_count, 64);
        chk("R4 no overrun at full", rx_overrun, 0);
        push_rx(8'hEE);
        chk("R3 shallow rx drop", rx_count, 64);
        chk("R4 shallow overrun", rx_overrun, 1);
        for (int i = 0; i < 64; i++) read_rx("R2 shallow order", 8'(i * 3 + 1));
        chk("R1 shallow drained", rx_count, 0);
        chk("R4 overrun holds until status read", rx_overrun, 1);
        stat_rd = 1'b1; rx_push = 1'b1; rx_din = 8'h00;
        tick();
        stat_rd = 1'b0; rx_push = 1'b0;
        chk("R4 status read with accepted push clears", rx_overrun, 0);
        read_rx("R2 single entry", 8'h00);
    endtask

    task automatic t_wrap();
        for (int i = 0; i < 40; i++) push_rx(8'(i));
        for (int i = 0; i < 30; i++) read_rx("R2 wrap first pass", 8'(i));
        for (int i = 40; i < 90; i++) push_rx(8'(i));
        chk("R1 wrap count", rx_count, 60);
        chk("R2 wrap head", rx_dout, 30);
        rx_rd = 1'b1; rx_push = 1'b1; rx_din = 8'd90;
        tick();
        rx_rd = 1'b0; rx_push = 1'b0;
        chk("R11 push and pop together", rx_count, 60);
        for (int i = 31; i <= 90; i++) read_rx("R2 wrap second pass", 8'(i));
        chk("R1 wrap drained", rx_count, 0);
    endtask

    task automatic t_tables();
        int tx_t[4] = '{8, 16, 32, 56};
        int rx_t[4] = '{8, 16, 56, 60};
        int up_t[4] = '{8, 16, 56, 60};
        int lo_t[4] = '{0, 8, 16, 56};
        for (int c = 0; c < 4; c++) begin
            code_tx_trig = 2'(c); code_rx_trig = 2'(c);
            code_upper = 2'(c); code_lower = 2'(c);
            #1ns;
            chk("R5 table tx trig", lvl_tx_trig, tx_t[c]);
            chk("R5 table rx trig", lvl_rx_trig, rx_t[c]);
            chk("R5 table upper", lvl_upper, up_t[c]);
            chk("R5 table lower", lvl_lower, lo_t[c]);
        end
        code_tx_trig = 2'd0; code_rx_trig = 2'd0; code_upper = 2'd0; code_lower = 2'd0;
    endtask

    task automatic t_regs();
        wr_lvl(2'd0, 8'd3);
        chk("R6 shallow write ignored, table shown", lvl_tx_trig, 8);
        set_mode(1'b1, 1'b1);
        chk("R6 reset tx trig", lvl_tx_trig, 16);
        chk("R6 reset rx trig", lvl_rx_trig, 16);
        chk("R6 reset upper", lvl_upper, 240);
        chk("R6 reset lower", lvl_lower, 16);
        wr_lvl(2'd0, 8'd3);
        wr_lvl(2'd1, 8'd5);
        wr_lvl(2'd2, 8'd10);
        wr_lvl(2'd3, 8'd4);
        chk("R6 write tx trig", lvl_tx_trig, 3);
        chk("R6 write rx trig", lvl_rx_trig, 5);
        chk("R6 write upper", lvl_upper, 10);
        chk("R6 write lower", lvl_lower, 4);
        code_tx_trig = 2'd3; code_rx_trig = 2'd3; code_upper = 2'd3; code_lower = 2'd3;
        #1ns;
        chk("R7 codes ignored tx", lvl_tx_trig, 3);
        chk("R7 codes ignored upper", lvl_upper, 10);
        code_tx_trig = 2'd0; code_rx_trig = 2'd0; code_upper = 2'd0; code_lower = 2'd0;
    endtask

    task automatic t_deep();
        chk("R1 deep tx_free", tx_free, 256);
        for (int i = 0; i < 256; i++) write_tx(8'(i) ^ 8'hC3);
        chk("R1 deep tx full", tx_free, 0);
        write_tx(8'h55);
        chk("R3 deep tx drop", tx_free, 0);
        for (int i = 0; i < 256; i++) begin
            chk("R2 deep tx order", tx_dout, 8'(i) ^ 8'hC3);
            tx_pop = 1'b1; tick(); tx_pop = 1'b0;
        end
        chk("R1 deep tx drained", tx_free, 256);
    endtask

    task automatic t_trig();
        chk("R8 tx_irq empty", tx_irq, 1);
        chk("R8 rx_irq empty", rx_irq, 0);
        for (int i = 0; i < 4; i++) push_rx(8'(i));
        chk("R8 rx below level", rx_irq, 0);
        push_rx(8'd4);
        chk("R8 rx at level", rx_irq, 1);
        for (int i = 0; i < 3; i++) write_tx(8'(i));
        chk("R8 tx at level", tx_irq, 1);
        write_tx(8'd3);
        chk("R8 tx above level", tx_irq, 0);
    endtask

    task automatic t_flow();
        for (int i = 5; i < 10; i++) push_rx(8'(i));
        tick();
        chk("R9 at upper no stop", flow_stop, 0);
        push_rx(8'd10);
        chk("R9 stop lags count", flow_stop, 0);
        tick();
        chk("R9 stop above upper", flow_stop, 1);
        for (int i = 0; i < 7; i++) read_rx("R2 flow order", 8'(i));
        tick();
        chk("R9 hold at lower", flow_stop, 1);
        read_rx("R2 flow order", 8'd7);
        chk("R9 clear lags count", flow_stop, 1);
        tick();
        chk("R9 clear below lower", flow_stop, 0);
    endtask

    task automatic t_flush();
        for (int i = 0; i < 12; i++) push_rx(8'(i));
        tick();
        chk("R9 stop before flush", flow_stop, 1);
        fifo_deep = 1'b0; rx_push = 1'b1; rx_din = 8'h77;
        tick();
        rx_push = 1'b0;
        chk("R10 flush rx", rx_count, 0);
        chk("R10 flush tx", tx_free, 64);
        chk("R10 flush clears stop", flow_stop, 0);
        chk("R10 shallow table back", lvl_tx_trig, 8);
    endtask

    initial begin
        rst = 1'b1;
        fifo_en = 1'b0; fifo_deep = 1'b0;
        code_tx_trig = 2'd0; code_rx_trig = 2'd0; code_upper = 2'd0; code_lower = 2'd0;
        lvl_wr_en = 1'b0; lvl_wr_sel = 2'd0; lvl_wr_data = 8'd0;
        tx_wr_en = 1'b0; tx_wr_data = 8'd0; tx_pop = 1'b0;
        rx_push = 1'b0; rx_din = 8'd0; rx_rd = 1'b0; stat_rd = 1'b0;
        repeat (3) tick();
        rst = 1'b0;
        tick();
        t_reset();
        t_single();
        t_shallow();
        t_wrap();
        t_tables();
        t_regs();
        t_deep();
        t_trig();
        t_flow();
        t_flush();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule